// File: doc/BRIEF.md
# Windowed Stacked Integer Register File

This block is an integer register file in which every procedure sees its own window of registers. Logical register numbers fall into two groups. The low static group maps straight onto dedicated storage and is shared by all procedures. The high stacked group is translated through a frame base pointer into a circular pool of physical slots. Each entry holds a data word together with a tag bit that marks a deferred exception. The block has two combinational read ports and one write port.

A procedure sizes its frame with an allocate command. The command gives the count of inputs plus locals and the total frame size. A call moves the frame base up past the caller's inputs and locals, so the caller's output registers become the callee's first registers and no data is copied. The caller's frame description is pushed onto an internal marker stack, and a return pops it to restore the caller's view. The pool wraps modulo its size, and no data is moved to or from memory.

Top module: `winreg_file`

## Requirements
- R1: After reset every static register reads data 0 and tag 0, the frame size is 0, and every stacked register reads as out of frame.
- R2: Register 0 always reads data 0, tag 0 and out-of-frame 0. A write to it is dropped, and it is never bypassed to a read.
- R3: Registers 1 to N_STATIC-1 map directly, never read as out of frame, and keep their contents across calls and returns.
- R4: A write stores the data and the tag together, and they are visible from the next cycle. A read of the location being written in the same cycle returns the new data and tag.
- R5: Stacked register r with k = r - N_STATIC below the frame size uses pool slot (base + k) mod N_PHYS. If k is not below the frame size, a read returns data 0 and tag 0 with out-of-frame 1, and a write is dropped with no effect on any slot.
- R6: An allocate with total size at most MAX_FRAME and inputs-plus-locals at most the total size sets both counts and leaves the base unchanged. Any other allocate is ignored.
- R7: An accepted call sets base to (base + inputs_plus_locals) mod N_PHYS, sets the frame size to total minus inputs_plus_locals, and sets inputs_plus_locals to 0. Callee register N_STATIC+j is then caller register N_STATIC+inputs_plus_locals+j.
- R8: A return restores the base and both counts that were in force before the matching call.
- R9: The pool is circular. Frames that pass the top slot wrap to slot 0, and a deep callee may overwrite slots of an older frame.
- R10: A call while the marker stack holds MARK_DEPTH entries is ignored. A return while it is empty is ignored.
- R11: When several commands are raised in one cycle, only the highest-priority one acts: return first, then call, then allocate. This holds even when the winning command is then ignored.
- R12: A write in the same cycle as a command is translated with the frame in force before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_idx | input | LOG_W | Read port 0 logical register |
| rd0_data | output | DATA_W | Read port 0 data |
| rd0_tag | output | 1 | Read port 0 deferred-exception tag |
| rd0_oof | output | 1 | Read port 0 register outside current frame |
| rd1_idx | input | LOG_W | Read port 1 logical register |
| rd1_data | output | DATA_W | Read port 1 data |
| rd1_tag | output | 1 | Read port 1 deferred-exception tag |
| rd1_oof | output | 1 | Read port 1 register outside current frame |
| wr_en | input | 1 | Write enable |
| wr_idx | input | LOG_W | Write logical register |
| wr_data | input | DATA_W | Write data |
| wr_tag | input | 1 | Write deferred-exception tag |
| alloc_en | input | 1 | Allocate command |
| alloc_il | input | FSZ_W | Allocate: inputs plus locals |
| alloc_sof | input | FSZ_W | Allocate: total frame size |
| call_en | input | 1 | Call command |
| ret_en | input | 1 | Return command |

## Verification
A write can land in the same cycle as a call, a return or an allocate. It can also land in the same cycle as a read of the register being written. Directed cycles provoke both cases: a write to a caller output register arrives together with the call, and is then read through the callee's input name. Reads aimed at the target of the write check the bypass, including the register-0 and out-of-frame cases where no bypass is allowed. A long mixed-stimulus phase raises commands, writes and matching reads together. A behavioural model built on queues judges every cycle, and it applies the write under the old frame before the command.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;

   typedef enum logic [1:0] {
      FC_IDLE  = 2'd0,
      FC_ALLOC = 2'd1,
      FC_CALL  = 2'd2,
      FC_RET   = 2'd3
   } frame_cmd_e;

   // return outranks call, call outranks allocate
   function automatic frame_cmd_e pick_cmd(input logic ret_en,
                                           input logic call_en,
                                           input logic alloc_en);
      if (ret_en)        return FC_RET;
      else if (call_en)  return FC_CALL;
      else if (alloc_en) return FC_ALLOC;
      return FC_IDLE;
   endfunction

endpackage

// File: rtl/wrf_frame_ctl.sv
`timescale 1ns/1ps
module wrf_frame_ctl #(
   parameter int N_PHYS     = 96,
   parameter int MAX_FRAME  = 96,
   parameter int MARK_DEPTH = 8,
   parameter int SLOT_W     = 7,
   parameter int FSZ_W      = 7,
   parameter int DEP_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [FSZ_W-1:0]  alloc_il,
   input  logic [FSZ_W-1:0]  alloc_sof,
   input  logic              call_en,
   input  logic              ret_en,
   output logic [SLOT_W-1:0] base,
   output logic [FSZ_W-1:0]  il,
   output logic [FSZ_W-1:0]  sof,
   output logic [DEP_W-1:0]  depth
);
   import wrf_pkg::*;

   localparam int MK_W  = $clog2(MARK_DEPTH);
   localparam int SUM_W = ((SLOT_W > FSZ_W) ? SLOT_W : FSZ_W) + 1;

   logic [SLOT_W-1:0] mk_base [MARK_DEPTH];
   logic [FSZ_W-1:0]  mk_il   [MARK_DEPTH];
   logic [FSZ_W-1:0]  mk_sof  [MARK_DEPTH];

   frame_cmd_e        cmd;
   logic              full, empty, alloc_ok;
   logic [DEP_W-1:0]  dm1;
   logic [MK_W-1:0]   push_ix, pop_ix;
   logic [SUM_W-1:0]  nsum;
   logic [SLOT_W-1:0] callee_base;

   always_comb begin
      cmd      = pick_cmd(ret_en, call_en, alloc_en);
      full     = (depth == DEP_W'(MARK_DEPTH));
      empty    = (depth == '0);
      alloc_ok = (SUM_W'(alloc_sof) <= SUM_W'(MAX_FRAME)) && (alloc_il <= alloc_sof);
      dm1      = depth - DEP_W'(1);
      push_ix  = depth[MK_W-1:0];
      pop_ix   = dm1[MK_W-1:0];
      nsum     = SUM_W'(base) + SUM_W'(il);
      if (nsum >= SUM_W'(N_PHYS)) nsum = nsum - SUM_W'(N_PHYS);
      callee_base = nsum[SLOT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base  <= '0;
         il    <= '0;
         sof   <= '0;
         depth <= '0;
      end else begin
         unique case (cmd)
            FC_RET: if (!empty) begin
               base  <= mk_base[pop_ix];
               il    <= mk_il[pop_ix];
               sof   <= mk_sof[pop_ix];
               depth <= dm1;
            end
            FC_CALL: if (!full) begin
               base  <= callee_base;
               il    <= '0;
               sof   <= sof - il;
               depth <= depth + DEP_W'(1);
            end
            FC_ALLOC: if (alloc_ok) begin
               il  <= alloc_il;
               sof <= alloc_sof;
            end
            default: ;
         endcase
      end
   end

   // marker storage needs no reset: an entry is read only after it was pushed
   always_ff @(posedge clk) begin
      if (cmd == FC_CALL && !full) begin
         mk_base[push_ix] <= base;
         mk_il[push_ix]   <= il;
         mk_sof[push_ix]  <= sof;
      end
   end

endmodule

// File: rtl/wrf_xlate.sv
`timescale 1ns/1ps
module wrf_xlate #(
   parameter int N_STATIC = 32,
   parameter int N_PHYS   = 96,
   parameter int LOG_W    = 7,
   parameter int SLOT_W   = 7,
   parameter int FSZ_W    = 7,
   parameter int SIDX_W   = 5
) (
   input  logic [LOG_W-1:0]  idx,
   input  logic [SLOT_W-1:0] base,
   input  logic [FSZ_W-1:0]  sof,
   output logic              is_stat,
   output logic [SIDX_W-1:0] sidx,
   output logic [SLOT_W-1:0] slot,
   output logic              live,
   output logic              oof
);
   localparam int MW    = (SLOT_W > FSZ_W) ? SLOT_W : FSZ_W;
   localparam int SUM_W = ((MW > LOG_W) ? MW : LOG_W) + 1;

   logic [LOG_W-1:0] off;
   logic [SUM_W-1:0] sum;

   always_comb begin
      is_stat = (idx < LOG_W'(N_STATIC));
      sidx    = idx[SIDX_W-1:0];
      off     = idx - LOG_W'(N_STATIC);
      sum     = SUM_W'(base) + SUM_W'(off);
      if (sum >= SUM_W'(N_PHYS)) sum = sum - SUM_W'(N_PHYS);
      slot    = sum[SLOT_W-1:0];
      oof     = !is_stat && (SUM_W'(off) >= SUM_W'(sof));
      live    = is_stat ? (idx != '0) : !oof;
   end

endmodule

// File: rtl/wrf_store.sv
`timescale 1ns/1ps
module wrf_store #(
   parameter int DATA_W   = 64,
   parameter int N_STATIC = 32,
   parameter int N_PHYS   = 96,
   parameter int N_RD     = 2,
   parameter int BYPASS   = 1,
   parameter int SIDX_W   = 5,
   parameter int SLOT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w_stat_en,
   input  logic [SIDX_W-1:0] w_sidx,
   input  logic              w_pool_en,
   input  logic [SLOT_W-1:0] w_slot,
   input  logic [DATA_W-1:0] w_data,
   input  logic              w_tag,
   input  logic [N_RD-1:0]   r_stat,
   input  logic [SIDX_W-1:0] r_sidx [N_RD],
   input  logic [SLOT_W-1:0] r_slot [N_RD],
   input  logic [N_RD-1:0]   r_live,
   output logic [DATA_W-1:0] r_data [N_RD],
   output logic [N_RD-1:0]   r_tag
);
   localparam int ENT_W = DATA_W + 1;

   logic [ENT_W-1:0] stat_q [N_STATIC];
   logic [ENT_W-1:0] pool_q [N_PHYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_STATIC; i++) stat_q[i] <= '0;
         for (int i = 0; i < N_PHYS; i++)   pool_q[i] <= '0;
      end else begin
         if (w_stat_en) stat_q[w_sidx] <= {w_tag, w_data};
         if (w_pool_en) pool_q[w_slot] <= {w_tag, w_data};
      end
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      logic [ENT_W-1:0] held, pick;
      assign held = r_stat[p] ? stat_q[r_sidx[p]] : pool_q[r_slot[p]];
      if (BYPASS != 0) begin : g_byp
         logic hit;
         assign hit  = r_stat[p] ? (w_stat_en && (w_sidx == r_sidx[p]))
                                 : (w_pool_en && (w_slot == r_slot[p]));
         assign pick = hit ? {w_tag, w_data} : held;
      end else begin : g_nobyp
         assign pick = held;
      end
      assign r_data[p] = r_live[p] ? pick[DATA_W-1:0] : '0;
      assign r_tag[p]  = r_live[p] & pick[DATA_W];
   end

endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file #(
   parameter int DATA_W     = 64,
   parameter int N_LOG      = 128,
   parameter int N_STATIC   = 32,
   parameter int N_PHYS     = 96,
   parameter int MAX_FRAME  = 96,
   parameter int MARK_DEPTH = 8,
   parameter int BYPASS     = 1,
   localparam int LOG_W     = $clog2(N_LOG),
   localparam int FSZ_W     = $clog2(MAX_FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOG_W-1:0]  rd0_idx,
   output logic [DATA_W-1:0] rd0_data,
   output logic              rd0_tag,
   output logic              rd0_oof,
   input  logic [LOG_W-1:0]  rd1_idx,
   output logic [DATA_W-1:0] rd1_data,
   output logic              rd1_tag,
   output logic              rd1_oof,
   input  logic              wr_en,
   input  logic [LOG_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_tag,
   input  logic              alloc_en,
   input  logic [FSZ_W-1:0]  alloc_il,
   input  logic [FSZ_W-1:0]  alloc_sof,
   input  logic              call_en,
   input  logic              ret_en
);
   localparam int SLOT_W = $clog2(N_PHYS);
   localparam int SIDX_W = $clog2(N_STATIC);
   localparam int DEP_W  = $clog2(MARK_DEPTH + 1);
   localparam int N_XP   = 3;   // two read ports then the write port

   if (N_PHYS < MAX_FRAME) begin : g_bad_pool
      $error("pool smaller than largest frame");
   end
   if (N_PHYS < N_LOG - N_STATIC) begin : g_bad_range
      $error("pool smaller than stacked name range");
   end
   if (MARK_DEPTH < 2 || N_STATIC < 2) begin : g_bad_depth
      $error("marker depth and static count must be at least 2");
   end

   logic [SLOT_W-1:0] frm_base;
   logic [FSZ_W-1:0]  frm_il, frm_sof;
   logic [DEP_W-1:0]  frm_depth;

   wrf_frame_ctl #(
      .N_PHYS(N_PHYS), .MAX_FRAME(MAX_FRAME), .MARK_DEPTH(MARK_DEPTH),
      .SLOT_W(SLOT_W), .FSZ_W(FSZ_W), .DEP_W(DEP_W)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_il(alloc_il), .alloc_sof(alloc_sof),
      .call_en(call_en), .ret_en(ret_en),
      .base(frm_base), .il(frm_il), .sof(frm_sof), .depth(frm_depth)
   );

   logic [LOG_W-1:0]  x_idx  [N_XP];
   logic [SIDX_W-1:0] x_sidx [N_XP];
   logic [SLOT_W-1:0] x_slot [N_XP];
   logic [N_XP-1:0]   x_stat, x_live, x_oof;

   assign x_idx[0] = rd0_idx;
   assign x_idx[1] = rd1_idx;
   assign x_idx[2] = wr_idx;

   for (genvar x = 0; x < N_XP; x++) begin : g_xl
      wrf_xlate #(
         .N_STATIC(N_STATIC), .N_PHYS(N_PHYS), .LOG_W(LOG_W),
         .SLOT_W(SLOT_W), .FSZ_W(FSZ_W), .SIDX_W(SIDX_W)
      ) u_xl (
         .idx(x_idx[x]), .base(frm_base), .sof(frm_sof),
         .is_stat(x_stat[x]), .sidx(x_sidx[x]), .slot(x_slot[x]),
         .live(x_live[x]), .oof(x_oof[x])
      );
   end

   logic              wr_ok;
   logic [SIDX_W-1:0] rs_sidx [2];
   logic [SLOT_W-1:0] rs_slot [2];
   logic [DATA_W-1:0] rs_data [2];
   logic [1:0]        rs_tag;

   assign wr_ok = wr_en && x_live[2];
   for (genvar p = 0; p < 2; p++) begin : g_rp
      assign rs_sidx[p] = x_sidx[p];
      assign rs_slot[p] = x_slot[p];
   end

   wrf_store #(
      .DATA_W(DATA_W), .N_STATIC(N_STATIC), .N_PHYS(N_PHYS), .N_RD(2),
      .BYPASS(BYPASS), .SIDX_W(SIDX_W), .SLOT_W(SLOT_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .w_stat_en(wr_ok && x_stat[2]), .w_sidx(x_sidx[2]),
      .w_pool_en(wr_ok && !x_stat[2]), .w_slot(x_slot[2]),
      .w_data(wr_data), .w_tag(wr_tag),
      .r_stat(x_stat[1:0]), .r_sidx(rs_sidx), .r_slot(rs_slot),
      .r_live(x_live[1:0]), .r_data(rs_data), .r_tag(rs_tag)
   );

   assign rd0_data = rs_data[0];
   assign rd1_data = rs_data[1];
   assign rd0_tag  = rs_tag[0];
   assign rd1_tag  = rs_tag[1];
   assign rd0_oof  = x_oof[0];
   assign rd1_oof  = x_oof[1];

endmodule

// File: rtl/wrf_chk.sv
`timescale 1ns/1ps
module wrf_chk #(
   parameter int DATA_W     = 64,
   parameter int N_STATIC   = 32,
   parameter int N_PHYS     = 96,
   parameter int MAX_FRAME  = 96,
   parameter int MARK_DEPTH = 8,
   parameter int LOG_W      = 7,
   parameter int FSZ_W      = 7,
   parameter int SLOT_W     = 7,
   parameter int DEP_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LOG_W-1:0]  rd0_idx,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd0_tag,
   input logic              rd0_oof,
   input logic [LOG_W-1:0]  rd1_idx,
   input logic [DATA_W-1:0] rd1_data,
   input logic              rd1_tag,
   input logic              rd1_oof,
   input logic              alloc_en,
   input logic [FSZ_W-1:0]  alloc_il,
   input logic [FSZ_W-1:0]  alloc_sof,
   input logic              call_en,
   input logic              ret_en,
   input logic [SLOT_W-1:0] frm_base,
   input logic [FSZ_W-1:0]  frm_il,
   input logic [FSZ_W-1:0]  frm_sof,
   input logic [DEP_W-1:0]  frm_depth
);
   logic call_acc, ret_acc, full;
   assign full     = (frm_depth == DEP_W'(MARK_DEPTH));
   assign call_acc = call_en && !ret_en && !full;
   assign ret_acc  = ret_en && (frm_depth != '0);

   a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_idx == '0) |-> (rd0_data == '0 && !rd0_tag && !rd0_oof));

   a_r5_oof_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_oof || rd1_oof) |-> ((!rd0_oof || (rd0_data == '0 && !rd0_tag)) &&
                                (!rd1_oof || (rd1_data == '0 && !rd1_tag))));

   a_r3_static_never_oof: assert property (@(posedge clk) disable iff (!rst_n)
      (rd1_idx < LOG_W'(N_STATIC)) |-> !rd1_oof);

   a_r9_base_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(frm_base) < N_PHYS));

   a_r7_call_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      call_acc |=> (frm_il == '0 && frm_sof == $past(frm_sof) - $past(frm_il)));

   a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(call_acc) && ret_acc) |=> (frm_base == $past(frm_base, 2) &&
                                         frm_sof == $past(frm_sof, 2)));

   a_r10_full_call_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (call_en && !ret_en && full) |=> ($stable(frm_base) && $stable(frm_depth)));

   a_r11_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_acc && call_en) |=> (frm_depth == $past(frm_depth) - DEP_W'(1)));

   a_r6_bad_alloc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !call_en && !ret_en &&
       (int'(alloc_sof) > MAX_FRAME || alloc_il > alloc_sof))
      |=> ($stable(frm_sof) && $stable(frm_il)));

endmodule

bind winreg_file wrf_chk #(
   .DATA_W(DATA_W), .N_STATIC(N_STATIC), .N_PHYS(N_PHYS), .MAX_FRAME(MAX_FRAME),
   .MARK_DEPTH(MARK_DEPTH), .LOG_W(LOG_W), .FSZ_W(FSZ_W), .SLOT_W(SLOT_W), .DEP_W(DEP_W)
) u_chk (.*);

// File: tb/sim_winreg_file.sv
`timescale 1ns/1ps
module sim_winreg_file;
   localparam int NP   = 96;
   localparam int NS   = 32;
   localparam int MAXF = 96;
   localparam int DEP  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
   logic [63:0] rd0_data, rd1_data, wr_data = '0;
   logic        rd0_tag, rd1_tag, rd0_oof, rd1_oof;
   logic        wr_en = 1'b0, wr_tag = 1'b0;
   logic        alloc_en = 1'b0, call_en = 1'b0, ret_en = 1'b0;
   logic [6:0]  alloc_il = '0, alloc_sof = '0;

   always #2.5 clk = ~clk;

   winreg_file u0 (
      .clk(clk), .rst_n(rst_n),
      .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_tag(rd0_tag), .rd0_oof(rd0_oof),
      .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_tag(rd1_tag), .rd1_oof(rd1_oof),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_tag(wr_tag),
      .alloc_en(alloc_en), .alloc_il(alloc_il), .alloc_sof(alloc_sof),
      .call_en(call_en), .ret_en(ret_en)
   );

   int n_run = 0, n_fail = 0;

   // behavioural reference
   logic [64:0] m_stat [NS];
   logic [64:0] m_pool [NP];
   int m_base = 0, m_il = 0, m_sof = 0;
   int mk_b[$], mk_i[$], mk_s[$];

   // stimulus of the current cycle
   bit s_we, s_wt, s_al, s_ca, s_re;
   int s_wi, s_r0, s_r1, s_ail, s_asof;
   logic [63:0] s_wd;

   task automatic clr();
      s_we = 0; s_wt = 0; s_al = 0; s_ca = 0; s_re = 0;
      s_wi = 0; s_r0 = 0; s_r1 = 0; s_ail = 0; s_asof = 0; s_wd = '0;
   endtask

   task automatic expect_rd(input int idx, output logic [63:0] d, output bit t, output bit o);
      int k;
      d = '0; t = 0; o = 0;
      if (idx == 0) return;
      if (idx < NS) begin
         if (s_we && s_wi == idx) begin d = s_wd; t = s_wt; end
         else begin d = m_stat[idx][63:0]; t = m_stat[idx][64]; end
         return;
      end
      k = idx - NS;
      if (k >= m_sof) begin o = 1; return; end
      if (s_we && s_wi == idx) begin d = s_wd; t = s_wt; end
      else begin d = m_pool[(m_base + k) % NP][63:0]; t = m_pool[(m_base + k) % NP][64]; end
   endtask

   task automatic chk(input string tag, input int port, input int idx,
                      input logic [63:0] ad, input bit at, input bit ao);
      logic [63:0] ed; bit et, eo;
      expect_rd(idx, ed, et, eo);
      n_run++;
      if (ad !== ed || at !== et || ao !== eo) begin
         n_fail++;
         $display("FAIL %s port%0d r%0d: got d=%h t=%0b o=%0b exp d=%h t=%0b o=%0b",
                  tag, port, idx, ad, at, ao, ed, et, eo);
      end
   endtask

   task automatic model_update();
      int k;
      if (s_we && s_wi != 0) begin
         if (s_wi < NS) m_stat[s_wi] = {s_wt, s_wd};
         else begin
            k = s_wi - NS;
            if (k < m_sof) m_pool[(m_base + k) % NP] = {s_wt, s_wd};
         end
      end
      if (s_re) begin
         if (mk_b.size() > 0) begin
            m_base = mk_b.pop_back(); m_il = mk_i.pop_back(); m_sof = mk_s.pop_back();
         end
      end else if (s_ca) begin
         if (mk_b.size() < DEP) begin
            mk_b.push_back(m_base); mk_i.push_back(m_il); mk_s.push_back(m_sof);
            m_base = (m_base + m_il) % NP; m_sof = m_sof - m_il; m_il = 0;
         end
      end else if (s_al) begin
         if (s_asof <= MAXF && s_ail <= s_asof) begin m_il = s_ail; m_sof = s_asof; end
      end
   endtask

   // one cycle: drive at negedge, compare, advance model, wait next negedge
   task automatic step(input string tag);
      wr_en = s_we; wr_idx = 7'(s_wi); wr_data = s_wd; wr_tag = s_wt;
      rd0_idx = 7'(s_r0); rd1_idx = 7'(s_r1);
      alloc_en = s_al; alloc_il = 7'(s_ail); alloc_sof = 7'(s_asof);
      call_en = s_ca; ret_en = s_re;
      #1;
      chk(tag, 0, s_r0, rd0_data, rd0_tag, rd0_oof);
      chk(tag, 1, s_r1, rd1_data, rd1_tag, rd1_oof);
      model_update();
      @(negedge clk);
   endtask

   task automatic rd(input string tag, input int a, input int b);
      clr(); s_r0 = a; s_r1 = b; step(tag);
   endtask
   task automatic wr(input string tag, input int i, input logic [63:0] d, input bit t);
      clr(); s_we = 1; s_wi = i; s_wd = d; s_wt = t; s_r0 = i; s_r1 = i; step(tag);
   endtask
   task automatic alloc(input string tag, input int il, input int sof);
      clr(); s_al = 1; s_ail = il; s_asof = sof; s_r0 = NS; s_r1 = NS + 11; step(tag);
   endtask
   task automatic call(input string tag);
      clr(); s_ca = 1; step(tag);
   endtask
   task automatic ret(input string tag);
      clr(); s_re = 1; step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NS; i++) m_stat[i] = '0;
      for (int i = 0; i < NP; i++) m_pool[i] = '0;
      clr();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd("R1", 5, 40);
      rd("R1", 31, 32);

      // R2 register 0: write dropped, no bypass
      wr("R2", 0, 64'hDEAD_BEEF_0000_0001, 1);
      rd("R2", 0, 0);

      // R3 / R4 static write, bypass, next-cycle visibility, tag
      wr("R4", 7, 64'h0123_4567_89AB_CDEF, 1);
      rd("R3", 7, 31);
      wr("R4", 31, 64'hFFFF_0000_FFFF_0000, 0);
      rd("R4", 31, 7);

      // R6 legal allocate, R5 mapping
      alloc("R6", 4, 10);
      for (int j = 0; j < 10; j++) wr("R5", NS + j, 64'h1000 + 64'(j), j[0]);
      for (int j = 0; j < 10; j += 2) rd("R5", NS + j, NS + j + 1);
      wr("R5", NS + 10, 64'hBAD, 1);   // outside frame: dropped
      rd("R5", NS + 10, NS + 95);

      // R6 illegal allocates ignored
      alloc("R6", 2, 97);
      rd("R6", NS + 9, NS + 10);
      alloc("R6", 11, 10);
      rd("R6", NS + 9, NS + 10);

      // R12 + R7: write to caller output r40 with call in same cycle
      clr(); s_ca = 1; s_we = 1; s_wi = NS + 8; s_wd = 64'hCA11; s_wt = 1;
      s_r0 = NS + 8; s_r1 = NS + 4; step("R12");
      rd("R7", NS + 0, NS + 4);   // callee r32 == caller r36, r36 == caller r40
      rd("R7", NS + 5, NS + 6);   // frame size 6: r38 out of frame
      alloc("R7", 2, 20);
      for (int j = 0; j < 20; j++) wr("R7", NS + j, 64'h2000 + 64'(j), 0);
      wr("R3", 7, 64'h7777, 0);
      ret("R8");
      for (int j = 0; j < 10; j += 2) rd("R8", NS + j, NS + j + 1);
      rd("R3", 7, NS + 10);

      // R11 priority
      clr(); s_re = 1; s_ca = 1; s_r0 = NS + 3; step("R11");   // ret wins, empty: nothing
      rd("R11", NS + 9, NS + 3);
      clr(); s_ca = 1; s_al = 1; s_ail = 1; s_asof = 1; step("R11");  // call wins
      rd("R11", NS + 0, NS + 6);
      clr(); s_re = 1; s_ca = 1; step("R11");   // ret acts
      rd("R11", NS + 0, NS + 9);

      // R10 marker stack limits
      for (int d = 0; d < DEP + 2; d++) begin
         alloc("R10", 1, 3);
         wr("R10", NS + 2, 64'h3000 + 64'(d), 1);
         call("R10");
         rd("R10", NS + 0, NS + 1);
      end
      for (int d = 0; d < DEP + 2; d++) begin
         ret("R10");
         rd("R10", NS + 0, NS + 2);
      end

      // R9 wrap: large frames pushed around the pool
      for (int d = 0; d < 4; d++) begin
         alloc("R9", 50, 96);
         wr("R9", NS + 60, 64'h4000 + 64'(d), 0);
         wr("R9", NS + 95, 64'h5000 + 64'(d), 1);
         call("R9");
         rd("R9", NS + 10, NS + 45);
      end
      for (int d = 0; d < 4; d++) begin
         ret("R9");
         rd("R9", NS + 60, NS + 95);
      end

      // mixed stimulus, model compared every cycle
      for (int c = 0; c < 3000; c++) begin
         int sel;
         clr();
         sel = $urandom_range(0, 99);
         s_we = ($urandom_range(0, 2) != 0);
         s_wi = (sel < 10) ? $urandom_range(0, NS - 1) : NS + $urandom_range(0, 40);
         s_wd = {$urandom, $urandom};
         s_wt = $urandom_range(0, 1);
         s_r0 = ($urandom_range(0, 3) == 0) ? s_wi : $urandom_range(0, 127);
         s_r1 = NS + $urandom_range(0, 40);
         if (sel < 10) s_ca = 1;
         else if (sel < 19) s_re = 1;
         if (sel >= 5 && sel < 28) begin
            s_al = 1;
            s_asof = $urandom_range(0, 100);
            s_ail = $urandom_range(0, s_asof + 2);
         end
         step("R9");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule